// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block is a circular reorder buffer for an out-of-order core. Decoded operations take slots in program order, up to a small group per cycle. Each slot is named by a tag that the scheduler hands to the function units. Results come back on several writeback ports, carrying the tag, a value and a completion status. The buffer commits completed slots from its head, up to three per cycle and strictly in order. For each committed slot it presents the destination register, the value and the tag. The architectural register file and the rename table consume these.

Each slot holds an occupied bit, a status, a destination register and a value. Operand read ports let the issue stage fetch a value by tag while its producer is still in flight.

When the oldest slot completed with a fault or a branch misprediction, the block raises a flush. It drives a redirect target taken from that slot's value and empties itself at the next edge. Head and tail pointers carry one extra wrap bit, so that a full buffer and an empty one are told apart. The depth must be a power of two.

Top module: `rob_multi_retire`

## Requirements
- R1: After reset the buffer is empty: no slot retires, `flush` is low, `alloc_tag` is 0 and every read port reports not ready.
- R2: When `alloc_ok` is high, a group of `alloc_cnt` slots (0 to ALLOC_W) is taken at the clock edge. Slot k of the group gets tag (`alloc_tag` + k) mod DEPTH and destination `alloc_dst[k]`. Each new slot starts with status pending (0) and value 0.
- R3: `alloc_ok` is low whenever fewer than `alloc_cnt` slots are free, and nothing is allocated then. Exactly DEPTH slots can be occupied at once.
- R4: A writeback port with `wb_valid` set writes `wb_value` and `wb_status` into the occupied slot named by `wb_tag`. The status codes are 0 pending, 1 done, 2 fault, 3 mispredict. A writeback to an unoccupied slot has no effect.
- R5: Read port r returns the value stored in slot `rd_tag[r]`. `rd_ready[r]` is high exactly when that slot is occupied with status done. Both reflect the state before the current edge.
- R6: Slot k of the retire outputs covers tag (head + k) mod DEPTH. Up to RET_W slots retire per cycle, each showing its tag, destination and value. The valid bits form a contiguous run starting at slot 0.
- R7: Retirement in a cycle stops at the first slot that is not done, or that is unoccupied. Younger slots do not commit that cycle, even if they are done.
- R8: When the head slot is occupied with status fault or mispredict, `flush` is high and `redirect_pc` equals that slot's value. In that cycle nothing retires and allocation is refused. After the edge the buffer is empty.
- R9: Done slots older than a faulting slot retire first. The flush follows in a later cycle, once the faulting slot has reached the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_cnt | input | CNT_W | Number of slots requested this cycle |
| alloc_dst | input | ALLOC_W x REG_W | Destination register per requested slot |
| alloc_ok | output | 1 | Allocation accepted at this edge |
| alloc_tag | output | IDX_W | Tag of the first slot of the group (tail) |
| wb_valid | input | NUM_WB | Writeback strobe per port |
| wb_tag | input | NUM_WB x IDX_W | Target slot per writeback port |
| wb_status | input | NUM_WB x 2 | Completion status per port |
| wb_value | input | NUM_WB x DATA_W | Result value per port |
| rd_tag | input | NUM_RD x IDX_W | Slot read by each operand port |
| rd_value | output | NUM_RD x DATA_W | Stored value per read port |
| rd_ready | output | NUM_RD | Slot occupied and done |
| ret_valid | output | RET_W | Retire strobe per slot of the group |
| ret_tag | output | RET_W x IDX_W | Tag of each retiring slot |
| ret_dst | output | RET_W x REG_W | Destination of each retiring slot |
| ret_value | output | RET_W x DATA_W | Value of each retiring slot |
| flush | output | 1 | Recovery: buffer empties at this edge |
| redirect_pc | output | DATA_W | Restart target from the faulting slot |

## Verification
The bench builds the block with its defaults: DEPTH 8, groups of up to three for allocation and retirement, two writeback ports and two read ports. With only eight slots, the pointers wrap many times in a few thousand cycles. The full condition and refusals of every group size are reached repeatedly. Retire groups can straddle the wrap point, and flushes land with the tail at every position. A bench-side model of the slot contents predicts every output in every cycle, under directed sequences and under a long pseudo-random sweep.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int DATA_W = 16;
    localparam int REG_W  = 5;

    typedef enum logic [1:0] {
        ST_PEND  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2,
        ST_MISP  = 2'd3
    } rob_status_e;

    typedef struct packed {
        logic              busy;
        rob_status_e       st;
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] val;
    } rob_entry_t;

    function automatic logic needs_recovery(rob_status_e s);
        return (s == ST_FAULT) || (s == ST_MISP);
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH   = 8,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = IDX_W + 1,
    localparam int CNT_W  = $clog2(ALLOC_W + 1),
    localparam int RN_W   = $clog2(RET_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] alloc_cnt,
    input  logic             flush,
    input  logic [RN_W-1:0]  ret_n,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [PTR_W-1:0] occ,
    output logic             alloc_ok
);

    logic [PTR_W-1:0] head_q, tail_q;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign occ      = tail_q - head_q;
    assign alloc_ok = !flush && (int'(alloc_cnt) <= DEPTH - int'(occ));

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            head_q <= tail_q;
        end else begin
            head_q <= head_q + PTR_W'(ret_n);
            if (alloc_ok)
                tail_q <= tail_q + PTR_W'(alloc_cnt);
        end
    end

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    parameter int NUM_WB  = 2,
    parameter int NUM_RD  = 2,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(ALLOC_W + 1),
    localparam int RN_W   = $clog2(RET_W + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             flush,
    input  logic                             alloc_go,
    input  logic [CNT_W-1:0]                 alloc_cnt,
    input  logic [ALLOC_W-1:0][REG_W-1:0]    alloc_dst,
    input  logic [IDX_W-1:0]                 tail_idx,
    input  logic [IDX_W-1:0]                 head_idx,
    input  logic [RN_W-1:0]                  ret_n,
    input  logic [NUM_WB-1:0]                wb_valid,
    input  logic [NUM_WB-1:0][IDX_W-1:0]     wb_tag,
    input  logic [NUM_WB-1:0][1:0]           wb_status,
    input  logic [NUM_WB-1:0][DATA_W-1:0]    wb_value,
    input  logic [NUM_RD-1:0][IDX_W-1:0]     rd_tag,
    output rob_entry_t [DEPTH-1:0]           ent,
    output logic [NUM_RD-1:0][DATA_W-1:0]    rd_value,
    output logic [NUM_RD-1:0]                rd_ready
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_entry_t       slot_q, slot_d;
        logic [IDX_W-1:0] off_alloc, off_ret;
        logic             hit_alloc, hit_ret;
        logic [REG_W-1:0] dst_sel;

        assign off_alloc = IDX_W'(i) - tail_idx;
        assign off_ret   = IDX_W'(i) - head_idx;
        assign hit_alloc = alloc_go && (int'(off_alloc) < int'(alloc_cnt));
        assign hit_ret   = int'(off_ret) < int'(ret_n);

        always_comb begin
            dst_sel = '0;
            for (int k = 0; k < ALLOC_W; k++)
                if (int'(off_alloc) == k)
                    dst_sel = alloc_dst[k];
        end

        always_comb begin
            slot_d = slot_q;
            if (hit_ret) begin
                slot_d.busy = 1'b0;
            end else if (hit_alloc) begin
                slot_d.busy = 1'b1;
                slot_d.st   = ST_PEND;
                slot_d.dst  = dst_sel;
                slot_d.val  = '0;
            end else if (slot_q.busy) begin
                for (int p = 0; p < NUM_WB; p++) begin
                    if (wb_valid[p] && (wb_tag[p] == IDX_W'(i))) begin
                        slot_d.st  = rob_status_e'(wb_status[p]);
                        slot_d.val = wb_value[p];
                    end
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst || flush)
                slot_q <= '0;
            else
                slot_q <= slot_d;
        end

        assign ent[i] = slot_q;
    end

    always_comb begin
        for (int r = 0; r < NUM_RD; r++) begin
            rd_value[r] = ent[rd_tag[r]].val;
            rd_ready[r] = ent[rd_tag[r]].busy && (ent[rd_tag[r]].st == ST_DONE);
        end
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RET_W  = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int RN_W  = $clog2(RET_W + 1)
) (
    input  rob_entry_t [DEPTH-1:0]         ent,
    input  logic [IDX_W-1:0]               head_idx,
    input  logic [PTR_W-1:0]               occ,
    output logic [RET_W-1:0]               ret_valid,
    output logic [RET_W-1:0][IDX_W-1:0]    ret_tag,
    output logic [RET_W-1:0][REG_W-1:0]    ret_dst,
    output logic [RET_W-1:0][DATA_W-1:0]   ret_value,
    output logic [RN_W-1:0]                ret_n,
    output logic                           flush,
    output logic [DATA_W-1:0]              redirect_pc
);

    rob_entry_t head_ent;

    assign head_ent    = ent[head_idx];
    assign flush       = head_ent.busy && needs_recovery(head_ent.st);
    assign redirect_pc = head_ent.val;

    always_comb begin
        logic       run;
        int         n;
        rob_entry_t e;
        run = 1'b1;
        n   = 0;
        for (int k = 0; k < RET_W; k++) begin
            ret_tag[k]   = head_idx + IDX_W'(k);
            e            = ent[ret_tag[k]];
            ret_dst[k]   = e.dst;
            ret_value[k] = e.val;
            ret_valid[k] = run && (k < int'(occ)) && e.busy && (e.st == ST_DONE);
            if (ret_valid[k])
                n = n + 1;
            else
                run = 1'b0;
        end
        ret_n = RN_W'(n);
    end

endmodule

// File: rtl/rob_multi_retire.sv
module rob_multi_retire
    import rob_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    parameter int NUM_WB  = 2,
    parameter int NUM_RD  = 2,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = IDX_W + 1,
    localparam int CNT_W  = $clog2(ALLOC_W + 1),
    localparam int RN_W   = $clog2(RET_W + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [CNT_W-1:0]               alloc_cnt,
    input  logic [ALLOC_W-1:0][REG_W-1:0]  alloc_dst,
    output logic                           alloc_ok,
    output logic [IDX_W-1:0]               alloc_tag,
    input  logic [NUM_WB-1:0]              wb_valid,
    input  logic [NUM_WB-1:0][IDX_W-1:0]   wb_tag,
    input  logic [NUM_WB-1:0][1:0]         wb_status,
    input  logic [NUM_WB-1:0][DATA_W-1:0]  wb_value,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_tag,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_value,
    output logic [NUM_RD-1:0]              rd_ready,
    output logic [RET_W-1:0]               ret_valid,
    output logic [RET_W-1:0][IDX_W-1:0]    ret_tag,
    output logic [RET_W-1:0][REG_W-1:0]    ret_dst,
    output logic [RET_W-1:0][DATA_W-1:0]   ret_value,
    output logic                           flush,
    output logic [DATA_W-1:0]              redirect_pc
);

    logic [IDX_W-1:0]       head_idx, tail_idx;
    logic [PTR_W-1:0]       occ;
    logic [RN_W-1:0]        ret_n;
    rob_entry_t [DEPTH-1:0] ent;

    assign alloc_tag = tail_idx;

    rob_ptr_ctrl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .alloc_cnt(alloc_cnt),
        .flush    (flush),
        .ret_n    (ret_n),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .occ      (occ),
        .alloc_ok (alloc_ok)
    );

    rob_entry_array #(
        .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W),
        .NUM_WB(NUM_WB), .NUM_RD(NUM_RD)
    ) u_arr (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .alloc_go (alloc_ok),
        .alloc_cnt(alloc_cnt),
        .alloc_dst(alloc_dst),
        .tail_idx (tail_idx),
        .head_idx (head_idx),
        .ret_n    (ret_n),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag),
        .wb_status(wb_status),
        .wb_value (wb_value),
        .rd_tag   (rd_tag),
        .ent      (ent),
        .rd_value (rd_value),
        .rd_ready (rd_ready)
    );

    rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ret (
        .ent        (ent),
        .head_idx   (head_idx),
        .occ        (occ),
        .ret_valid  (ret_valid),
        .ret_tag    (ret_tag),
        .ret_dst    (ret_dst),
        .ret_value  (ret_value),
        .ret_n      (ret_n),
        .flush      (flush),
        .redirect_pc(redirect_pc)
    );

endmodule

// File: rtl/rob_mr_checker.sv
module rob_mr_checker #(
    parameter int DEPTH   = 8,
    parameter int ALLOC_W = 3,
    parameter int RET_W   = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(ALLOC_W + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [CNT_W-1:0]            alloc_cnt,
    input logic                        alloc_ok,
    input logic [RET_W-1:0]            ret_valid,
    input logic [RET_W-1:0][IDX_W-1:0] ret_tag,
    input logic                        flush
);

    // occupancy rebuilt from port activity only
    int occ_seen;

    always_ff @(posedge clk) begin
        if (rst || flush)
            occ_seen <= 0;
        else
            occ_seen <= occ_seen + (alloc_ok ? int'(alloc_cnt) : 0) - $countones(ret_valid);
    end

    // R3: an accepted group never overfills the buffer
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (alloc_ok && alloc_cnt != '0) |-> (occ_seen + int'(alloc_cnt) <= DEPTH));

    // R6: retire strobes are a run starting at slot 0
    a_r6_contiguous: assert property (@(posedge clk) disable iff (rst)
        ((ret_valid & (ret_valid + RET_W'(1))) == '0));

    // R6: no more slots retire than are held
    a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
        ($countones(ret_valid) <= occ_seen));

    for (genvar k = 1; k < RET_W; k++) begin : g_ord
        // R6: retiring tags are consecutive
        a_r6_tag_order: assert property (@(posedge clk) disable iff (rst)
            ret_valid[k] |-> (ret_tag[k] == ret_tag[k-1] + IDX_W'(1)));
    end

    // R8: recovery cycle neither retires nor allocates
    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        flush |-> (ret_valid == '0 && !alloc_ok));

    // R8: buffer is empty right after recovery
    a_r8_empty_after: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!flush && ret_valid == '0));

endmodule

bind rob_multi_retire rob_mr_checker #(
    .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .alloc_cnt(alloc_cnt),
    .alloc_ok (alloc_ok),
    .ret_valid(ret_valid),
    .ret_tag  (ret_tag),
    .flush    (flush)
);

// File: tb/tb_rob_multi_retire.sv
`timescale 1ns/1ps
module tb_rob_multi_retire;
    import rob_pkg::*;

    localparam int DEPTH = 8, AW = 3, RW = 3, NWB = 2, NRD = 2;
    localparam int IW = $clog2(DEPTH);

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0]                  alloc_cnt;
    logic [AW-1:0][REG_W-1:0]    alloc_dst;
    logic                        alloc_ok;
    logic [IW-1:0]               alloc_tag;
    logic [NWB-1:0]              wb_valid;
    logic [NWB-1:0][IW-1:0]      wb_tag;
    logic [NWB-1:0][1:0]         wb_status;
    logic [NWB-1:0][DATA_W-1:0]  wb_value;
    logic [NRD-1:0][IW-1:0]      rd_tag;
    logic [NRD-1:0][DATA_W-1:0]  rd_value;
    logic [NRD-1:0]              rd_ready;
    logic [RW-1:0]               ret_valid;
    logic [RW-1:0][IW-1:0]       ret_tag;
    logic [RW-1:0][REG_W-1:0]    ret_dst;
    logic [RW-1:0][DATA_W-1:0]   ret_value;
    logic                        flush;
    logic [DATA_W-1:0]           redirect_pc;

    always #10 clk = ~clk;

    rob_multi_retire #(.DEPTH(DEPTH), .ALLOC_W(AW), .RET_W(RW), .NUM_WB(NWB), .NUM_RD(NRD)) dut (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    // bench-side model of the slots
    bit m_busy [DEPTH];
    int m_st   [DEPTH];
    int m_dst  [DEPTH];
    int m_val  [DEPTH];
    int m_head = 0, m_cnt = 0;
    int rs = 32'h1234_5678;

    function automatic int rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >>> 17);
        rs = rs ^ (rs << 5);
        return rs & 32'h7fff_ffff;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_cnt = '0; alloc_dst = '0; wb_valid = '0; wb_tag = '0;
        wb_status = '0; wb_value = '0;
    endtask

    // called just after a falling edge with inputs driven
    task automatic cycle();
        int h, tail, n, t;
        bit e_flush, e_ok, run, v;
        #1;
        h = m_head;
        tail = (m_head + m_cnt) % DEPTH;
        e_flush = m_busy[h] && m_st[h] >= 2;
        e_ok = !e_flush && (int'(alloc_cnt) <= DEPTH - m_cnt);
        chk(flush == e_flush, "R8", "flush", flush, e_flush);
        if (e_flush) chk(redirect_pc == DATA_W'(m_val[h]), "R8", "redirect_pc", redirect_pc, m_val[h]);
        chk(alloc_ok == e_ok, "R3", "alloc_ok", alloc_ok, e_ok);
        chk(alloc_tag == IW'(tail), "R2", "alloc_tag", alloc_tag, tail);
        run = 1; n = 0;
        for (int k = 0; k < RW; k++) begin
            t = (h + k) % DEPTH;
            v = run && k < m_cnt && m_busy[t] && m_st[t] == 1;
            if (!v) run = 0; else n++;
            chk(ret_valid[k] == v, "R7", "ret_valid", ret_valid[k], v);
            if (v) begin
                chk(ret_tag[k] == IW'(t), "R6", "ret_tag", ret_tag[k], t);
                chk(ret_dst[k] == REG_W'(m_dst[t]), "R6", "ret_dst", ret_dst[k], m_dst[t]);
                chk(ret_value[k] == DATA_W'(m_val[t]), "R6", "ret_value", ret_value[k], m_val[t]);
            end
        end
        for (int r = 0; r < NRD; r++) begin
            t = rd_tag[r];
            v = m_busy[t] && m_st[t] == 1;
            chk(rd_ready[r] == v, "R5", "rd_ready", rd_ready[r], v);
            if (m_busy[t]) chk(rd_value[r] == DATA_W'(m_val[t]), "R5", "rd_value", rd_value[r], m_val[t]);
        end
        @(posedge clk);
        if (e_flush) begin
            for (int i = 0; i < DEPTH; i++) m_busy[i] = 0;
            m_head = tail; m_cnt = 0;
        end else begin
            for (int k = 0; k < n; k++) m_busy[(h + k) % DEPTH] = 0;
            for (int p = 0; p < NWB; p++)
                if (wb_valid[p] && m_busy[wb_tag[p]]) begin
                    m_st[wb_tag[p]] = wb_status[p];
                    m_val[wb_tag[p]] = wb_value[p];
                end
            if (e_ok)
                for (int k = 0; k < int'(alloc_cnt); k++) begin
                    t = (tail + k) % DEPTH;
                    m_busy[t] = 1; m_st[t] = 0; m_dst[t] = alloc_dst[k]; m_val[t] = 0;
                end
            m_head = (h + n) % DEPTH;
            m_cnt = m_cnt - n + (e_ok ? int'(alloc_cnt) : 0);
        end
        @(negedge clk);
        idle();
    endtask

    task automatic alloc(int n, int d0);
        alloc_cnt = 2'(n);
        for (int k = 0; k < AW; k++) alloc_dst[k] = REG_W'(d0 + k);
        cycle();
    endtask

    task automatic wb(int p, int tag, int st, int val);
        wb_valid[p] = 1'b1; wb_tag[p] = IW'(tag);
        wb_status[p] = 2'(st); wb_value[p] = DATA_W'(val);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_busy[i] = 0; m_st[i] = 0; m_dst[i] = 0; m_val[i] = 0;
        end
        idle(); rd_tag = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(ret_valid == '0, "R1", "ret_valid", ret_valid, 0);
        chk(!flush, "R1", "flush", flush, 0);
        chk(alloc_tag == '0, "R1", "alloc_tag", alloc_tag, 0);
        chk(rd_ready == '0, "R1", "rd_ready", rd_ready, 0);

        // R2 R3: fill to exactly DEPTH, then refuse
        alloc(3, 1); alloc(3, 4); alloc(2, 7);
        alloc_cnt = 2'd1;
        #1 chk(alloc_ok == 1'b0, "R3", "alloc_ok when full", alloc_ok, 0);
        cycle();
        // R4: writeback to slot 0 left pending; R7: younger done slots wait
        wb(0, 2, 1, 222); wb(1, 1, 1, 111); rd_tag[0] = 3'd1; cycle();
        rd_tag[0] = 3'd1; rd_tag[1] = 3'd2; cycle();
        wb(0, 0, 1, 100); cycle();
        // R6: three retire together
        wb(0, 3, 1, 33); wb(1, 4, 1, 44); cycle();
        wb(0, 5, 1, 55); wb(1, 6, 1, 66); cycle();
        wb(0, 7, 1, 77); cycle();
        repeat (3) cycle();
        // R9 then R8: older done slots go first, fault flushes later
        alloc(3, 20);
        wb(0, 0, 1, 5); wb(1, 1, 2, 16'hBEEF); cycle();
        wb(0, 2, 1, 9); cycle();
        alloc_cnt = 2'd2; cycle();
        cycle();
        // R8: mispredict with a competing allocation
        alloc(2, 10);
        wb(0, (m_head) % DEPTH, 3, 16'h0C40); alloc_cnt = 2'd3; cycle();
        alloc_cnt = 2'd3; cycle();
        // R4: writeback into an empty slot is ignored
        wb(0, (m_head + 2) % DEPTH, 1, 999); cycle();
        alloc(3, 0); rd_tag[0] = IW'((m_head + 2) % DEPTH); cycle();

        // near-exhaustive pseudo-random sweep
        for (int c = 0; c < 6000; c++) begin
            int x;
            x = rnd();
            alloc_cnt = 2'(x);
            for (int k = 0; k < AW; k++) alloc_dst[k] = REG_W'(x >> (2 + 5 * k));
            for (int p = 0; p < NWB; p++) begin
                int y;
                y = rnd();
                wb_valid[p] = y[0];
                wb_tag[p] = (p == 1 && y[3:1] == wb_tag[0]) ? IW'(y[3:1] + 1) : IW'(y[3:1]);
                wb_status[p] = (y[8:4] == 0) ? 2'd2 : (y[8:4] == 1) ? 2'd3 : (y[8:4] == 2) ? 2'd0 : 2'd1;
                wb_value[p] = DATA_W'(y >> 9);
            end
            for (int r = 0; r < NRD; r++) rd_tag[r] = IW'(x >> (20 + 3 * r));
            cycle();
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule